// File: doc/BRIEF.md
# Driver Impedance Calibration Controller

This controller picks how many parallel segments of a replica output leg are switched on, so that the replica matches a precision reference resistor. It sees the analog comparison only as one comparator bit and drives the replica with a trial code. When a search finishes it copies the result to the real driver. Both codes are presented either as a plain binary number or as a thermometer vector, one line per segment, selected by an input.

A full search runs on a start request. It is a successive-approximation search, one code bit per step, and each trial code is held for a fixed settle time before the comparator is sampled. After that first search the block either stops, or it keeps tracking the reference. Tracking can run at a programmable interval or back-to-back. A tracking step moves the code by at most one unit, so the driver impedance never jumps. A debug override forces any code onto both legs, and the binary value of the driver code can always be read back.

Top module: `zcal_ctrl`

## Requirements
- R1: After reset the replica and driver codes are zero, the done pulse is low and the error flag is low.
- R2: A start request in an idle or tracking state launches a search that tries the code bits from the most significant bit down. Each trial is held for SETTLE_CYC cycles. The done pulse appears CODE_W*SETTLE_CYC cycles after the clock edge that accepted the start.
- R3: A high comparator bit at the end of a settle window means "more segments needed or equal". It keeps the trial bit during a search and raises the code by one during tracking. A low bit clears the trial bit, or lowers the code by one during tracking.
- R4: With therm_sel_i high, output bit i of a code vector is 1 exactly when the code value is greater than i. With therm_sel_i low, the binary value sits in the low CODE_W bits and the upper bits are zero.
- R5: On every driver update the error flag is set if the new code is all zeros or all ones, and it is cleared otherwise.
- R6: The driver code changes only on the cycle its done pulse is high, or as the result of a forced code. It never changes in the middle of a search.
- R7: In periodic mode (mode_i = 1), after each completed update the block waits interval_i+1 cycles and then runs a tracking step. Updates are therefore interval_i+SETTLE_CYC+1 cycles apart.
- R8: In continuous mode (mode_i = 2), tracking steps follow one another, with updates SETTLE_CYC cycles apart.
- R9: In one-shot mode (mode_i = 0 or 3), no update follows a completed search until the next start request.
- R10: While force_en_i is high, both codes take force_code_i on the next edge, no search or tracking runs, start requests are ignored, and no done pulse occurs. After release the forced code stays in place.
- R11: A start request during a search is ignored. The search result and its latency are unchanged.
- R12: If the mode is one-shot when a tracking step reaches its decision, the step is dropped and the driver code is left untouched.
- R13: Tracking saturates: it never goes below zero or above the all-ones code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a full search |
| cmp_i | input | 1 | Comparator bit: 1 = replica needs more segments or is matched |
| mode_i | input | 2 | 0/3 one-shot, 1 periodic, 2 continuous |
| interval_i | input | INTERVAL_W | Periodic wait length in cycles |
| therm_sel_i | input | 1 | 1 = thermometer code vectors, 0 = binary |
| force_en_i | input | 1 | Debug override enable |
| force_code_i | input | CODE_W | Debug override code |
| rep_code_o | output | 2**CODE_W-1 | Segment enables of the replica leg |
| drv_code_o | output | 2**CODE_W-1 | Segment enables of the real driver |
| drv_bin_o | output | CODE_W | Binary readback of the driver code |
| done_o | output | 1 | One-cycle pulse on each driver update |
| err_o | output | 1 | Last result sat at a code rail |

## Verification
The comparator is modelled as a threshold on the replica code. The search is tried with thresholds in the middle of the range, exactly on the most significant trial bit, at zero and beyond the top. Together these show correct bit keeping, correct equal-case handling and the out-of-range flag. Tracking is tried with a threshold that moves after the search in both scheduling modes, which shows the step size and the update spacing, and with a threshold beyond the bottom rail, which shows saturation. Overlapping start requests, mode changes to one-shot while a tracking step is pending, and a forced code with a start request applied tell a driver that changes only on completions apart from one that leaks intermediate values.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAR  = 2'd1,
        ST_WAIT = 2'd2,
        ST_TRK  = 2'd3
    } zcal_state_e;

    localparam logic [1:0] MODE_ONCE = 2'd0;
    localparam logic [1:0] MODE_PER  = 2'd1;
    localparam logic [1:0] MODE_CONT = 2'd2;

endpackage

// File: rtl/zcal_step.sv
// Saturating one-unit step of a code, used by background tracking.
module zcal_step #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              up_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    always_comb begin
        if (up_i) begin
            code_o = (code_i == TOP) ? code_i : code_i + 1'b1;
        end else begin
            code_o = (code_i == '0) ? code_i : code_i - 1'b1;
        end
    end
endmodule

// File: rtl/zcal_enc.sv
// Presents a binary segment count as binary or thermometer enables.
module zcal_enc #(
    parameter int CODE_W = 5,
    parameter int OUT_W  = (1 << CODE_W) - 1
) (
    input  logic [CODE_W-1:0] bin_i,
    input  logic              therm_sel_i,
    output logic [OUT_W-1:0]  code_o
);
    logic [OUT_W-1:0] therm;

    for (genvar i = 0; i < OUT_W; i++) begin : g_seg
        assign therm[i] = (32'(bin_i) > i);
    end

    assign code_o = therm_sel_i ? therm : OUT_W'(bin_i);
endmodule

// File: rtl/zcal_seq.sv
// Search and tracking sequencer.
module zcal_seq
    import zcal_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int SETTLE_CYC = 4,
    parameter int INTERVAL_W = 12
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic                  cmp_i,
    input  logic [1:0]            mode_i,
    input  logic [INTERVAL_W-1:0] interval_i,
    input  logic                  force_en_i,
    input  logic [CODE_W-1:0]     force_code_i,
    output logic [CODE_W-1:0]     rep_bin_o,
    output logic [CODE_W-1:0]     drv_bin_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic                  trk_upd_o
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam int TMR_W = (INTERVAL_W > SET_W) ? INTERVAL_W : SET_W;
    localparam logic [TMR_W-1:0]  SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
    localparam logic [IDX_W-1:0]  IDX_TOP   = IDX_W'(CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_TOP  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MSB_ONLY  = {1'b1, {(CODE_W-1){1'b0}}};

    typedef struct packed {
        zcal_state_e         state;
        logic [TMR_W-1:0]    tmr;
        logic [IDX_W-1:0]    idx;
        logic [CODE_W-1:0]   rep;
        logic [CODE_W-1:0]   drv;
        logic                done;
        logic                err;
        logic                trk_upd;
    } seq_t;

    seq_t q, d;

    logic              is_per, is_cont, is_once;
    logic [CODE_W-1:0] kept, probe, step_code;

    function automatic logic at_rail(input logic [CODE_W-1:0] c);
        return (c == '0) || (c == CODE_TOP);
    endfunction

    zcal_step #(.CODE_W(CODE_W)) u_step (
        .code_i (q.drv),
        .up_i   (cmp_i),
        .code_o (step_code)
    );

    assign is_per  = (mode_i == MODE_PER);
    assign is_cont = (mode_i == MODE_CONT);
    assign is_once = !is_per && !is_cont;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.trk_upd = 1'b0;

        kept          = q.rep;
        kept[q.idx]   = cmp_i;
        probe         = kept;
        if (q.idx != '0) begin
            probe[q.idx - 1'b1] = 1'b1;
        end

        if (force_en_i) begin
            d.state = ST_IDLE;
            d.drv   = force_code_i;
            d.rep   = force_code_i;
            d.tmr   = '0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    d.tmr = '0;
                end
                ST_SAR: begin
                    if (q.tmr != '0) begin
                        d.tmr = q.tmr - 1'b1;
                    end else if (q.idx == '0) begin
                        d.rep  = kept;
                        d.drv  = kept;
                        d.done = 1'b1;
                        d.err  = at_rail(kept);
                        if (is_cont) begin
                            d.state = ST_TRK;
                            d.tmr   = SETTLE_LD;
                        end else if (is_per) begin
                            d.state = ST_WAIT;
                            d.tmr   = TMR_W'(interval_i);
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end else begin
                        d.rep = probe;
                        d.idx = q.idx - 1'b1;
                        d.tmr = SETTLE_LD;
                    end
                end
                ST_WAIT: begin
                    if (is_once) begin
                        d.state = ST_IDLE;
                    end else if (q.tmr == '0) begin
                        d.state = ST_TRK;
                        d.tmr   = SETTLE_LD;
                    end else begin
                        d.tmr = q.tmr - 1'b1;
                    end
                end
                ST_TRK: begin
                    if (q.tmr != '0) begin
                        d.tmr = q.tmr - 1'b1;
                    end else if (is_once) begin
                        d.state = ST_IDLE;
                    end else begin
                        d.drv     = step_code;
                        d.rep     = step_code;
                        d.done    = 1'b1;
                        d.trk_upd = 1'b1;
                        d.err     = at_rail(step_code);
                        if (is_cont) begin
                            d.state = ST_TRK;
                            d.tmr   = SETTLE_LD;
                        end else begin
                            d.state = ST_WAIT;
                            d.tmr   = TMR_W'(interval_i);
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase

            if (start_i && (q.state != ST_SAR)) begin
                d.state   = ST_SAR;
                d.idx     = IDX_TOP;
                d.rep     = MSB_ONLY;
                d.tmr     = SETTLE_LD;
                d.drv     = q.drv;
                d.err     = q.err;
                d.done    = 1'b0;
                d.trk_upd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rep_bin_o = q.rep;
    assign drv_bin_o = q.drv;
    assign done_o    = q.done;
    assign err_o     = q.err;
    assign trk_upd_o = q.trk_upd;
endmodule

// File: rtl/zcal_ctrl.sv
// Top: sequencer plus code presentation for replica and driver legs.
module zcal_ctrl #(
    parameter int CODE_W     = 5,
    parameter int SETTLE_CYC = 4,
    parameter int INTERVAL_W = 12,
    localparam int OUT_W     = (1 << CODE_W) - 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic                  cmp_i,
    input  logic [1:0]            mode_i,
    input  logic [INTERVAL_W-1:0] interval_i,
    input  logic                  therm_sel_i,
    input  logic                  force_en_i,
    input  logic [CODE_W-1:0]     force_code_i,
    output logic [OUT_W-1:0]      rep_code_o,
    output logic [OUT_W-1:0]      drv_code_o,
    output logic [CODE_W-1:0]     drv_bin_o,
    output logic                  done_o,
    output logic                  err_o
);
    logic [CODE_W-1:0] rep_bin;
    logic [CODE_W-1:0] drv_bin;
    logic              trk_upd;

    zcal_seq #(
        .CODE_W     (CODE_W),
        .SETTLE_CYC (SETTLE_CYC),
        .INTERVAL_W (INTERVAL_W)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .cmp_i        (cmp_i),
        .mode_i       (mode_i),
        .interval_i   (interval_i),
        .force_en_i   (force_en_i),
        .force_code_i (force_code_i),
        .rep_bin_o    (rep_bin),
        .drv_bin_o    (drv_bin),
        .done_o       (done_o),
        .err_o        (err_o),
        .trk_upd_o    (trk_upd)
    );

    zcal_enc #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_enc_rep (
        .bin_i       (rep_bin),
        .therm_sel_i (therm_sel_i),
        .code_o      (rep_code_o)
    );

    zcal_enc #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_enc_drv (
        .bin_i       (drv_bin),
        .therm_sel_i (therm_sel_i),
        .code_o      (drv_code_o)
    );

    assign drv_bin_o = drv_bin;
endmodule

// File: rtl/zcal_ctrl_chk.sv
module zcal_ctrl_chk #(
    parameter int CODE_W     = 5,
    parameter int SETTLE_CYC = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              force_en_i,
    input logic [CODE_W-1:0] force_code_i,
    input logic [CODE_W-1:0] drv_bin_o,
    input logic              done_o,
    input logic              err_o,
    input logic              trk_upd
);
    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

    // R6
    drv_only_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(drv_bin_o) |-> (done_o || $past(force_en_i)));

    // R10
    force_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(force_en_i) && $past(rst_ni)) |-> (drv_bin_o == $past(force_code_i)));

    // R10
    force_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(force_en_i) && $past(rst_ni)) |-> !done_o);

    // R13
    track_one_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trk_upd |-> ((drv_bin_o == $past(drv_bin_o)) ||
                     ({1'b0, drv_bin_o} == {1'b0, $past(drv_bin_o)} + 1'b1) ||
                     ({1'b0, $past(drv_bin_o)} == {1'b0, drv_bin_o} + 1'b1)));

    // R5
    rail_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (err_o == ((drv_bin_o == '0) || (drv_bin_o == CODE_TOP))));

    if (SETTLE_CYC > 1) begin : g_pulse
        // R2
        done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_o |=> !done_o);
    end
endmodule

bind zcal_ctrl zcal_ctrl_chk #(
    .CODE_W     (CODE_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .force_en_i   (force_en_i),
    .force_code_i (force_code_i),
    .drv_bin_o    (drv_bin_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .trk_upd      (trk_upd)
);

// File: tb/zcal_ctrl_tb.sv
module zcal_ctrl_tb;
    localparam int CW = 5;
    localparam int SC = 4;
    localparam int IW = 12;
    localparam int OW = (1 << CW) - 1;
    localparam int TOP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cmp;
    logic [1:0]    mode = 2'd0;
    logic [IW-1:0] interval = '0;
    logic          therm_sel = 1'b0;
    logic          force_en = 1'b0;
    logic [CW-1:0] force_code = '0;
    logic [OW-1:0] rep_code, drv_code;
    logic [CW-1:0] drv_bin;
    logic          done, err;

    int n_chk = 0;
    int n_fail = 0;
    int tgt = 0;
    int cur = 0;
    bit finished = 1'b0;

    typedef struct { int code; bit err; } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    zcal_ctrl #(.CODE_W(CW), .SETTLE_CYC(SC), .INTERVAL_W(IW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
        .mode_i(mode), .interval_i(interval), .therm_sel_i(therm_sel),
        .force_en_i(force_en), .force_code_i(force_code),
        .rep_code_o(rep_code), .drv_code_o(drv_code), .drv_bin_o(drv_bin),
        .done_o(done), .err_o(err)
    );

    // threshold comparator model
    int rep_val;
    always_comb rep_val = therm_sel ? $countones(rep_code) : int'(rep_code[CW-1:0]);
    assign cmp = (rep_val <= tgt);

    function automatic logic [OW-1:0] enc(input int code, input bit th);
        logic [OW-1:0] r;
        for (int i = 0; i < OW; i++) r[i] = th ? (i < code) : 1'b0;
        if (!th) r = OW'(code);
        return r;
    endfunction

    function automatic bit rail(input int c);
        return (c == 0) || (c == TOP);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compare each driver update against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected update", int'(drv_bin), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(drv_bin) == e.code, "R2 driver code", int'(drv_bin), e.code);
                check(err == e.err, "R5 error flag", int'(err), int'(e.err));
                check(drv_code == enc(e.code, therm_sel), "R4 code encoding",
                      int'(drv_code), int'(enc(e.code, therm_sel)));
            end
        end
    end

    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!done);
    endtask

    task automatic search(input int t, input bit restart_mid);
        int cyc;
        int res;
        tgt = t;
        res = (t < 0) ? 0 : ((t > TOP) ? TOP : t);
        sb.push_back('{res, rail(res)});
        cur = res;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = restart_mid && (cyc == 5);
        end while (!done);
        start = 1'b0;
        check(cyc == CW * SC, restart_mid ? "R11 latency" : "R2 latency", cyc, CW * SC);
    endtask

    task automatic track(input int n, input int spacing, input string req);
        int cyc;
        int nx = cur;
        for (int i = 0; i < n; i++) begin
            if (nx <= tgt) nx = (nx == TOP) ? nx : nx + 1;
            else           nx = (nx == 0) ? nx : nx - 1;
            sb.push_back('{nx, rail(nx)});
        end
        for (int i = 0; i < n; i++) begin
            wait_done(cyc);
            check(cyc == spacing, req, cyc, spacing);
        end
        mode = 2'd0;  // R12: pending step must be dropped
        cur = nx;
    endtask

    task automatic quiet(input int n, input string req);
        repeat (n) @(negedge clk);
        check(int'(drv_bin) == cur, req, int'(drv_bin), cur);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(drv_bin == '0, "R1 driver code", int'(drv_bin), 0);
        check(rep_code == '0, "R1 replica code", int'(rep_code), 0);
        check(done == 1'b0 && err == 1'b0, "R1 flags", int'({done, err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R9 one-shot binary search
        mode = 2'd0;
        search(19, 1'b0);
        quiet(30, "R9 no update after one-shot");
        // R4 thermometer output
        therm_sel = 1'b1;
        search(6, 1'b0);
        check(drv_code == enc(6, 1'b1), "R4 thermometer", int'(drv_code), int'(enc(6, 1'b1)));
        therm_sel = 1'b0;
        // R3 equality keeps the trial bit
        search(16, 1'b0);
        // R5 rails and clearing
        search(0, 1'b0);
        search(40, 1'b0);
        search(12, 1'b0);
        check(err == 1'b0, "R5 flag cleared", int'(err), 0);
        // R11 start during search ignored
        search(25, 1'b1);

        // R7 periodic tracking
        mode = 2'd1;
        interval = IW'(7);
        search(10, 1'b0);
        tgt = 13;
        track(6, 7 + SC + 1, "R7 periodic spacing");
        quiet(40, "R12 periodic stop");

        // R8 continuous tracking, R13 saturation at zero
        mode = 2'd2;
        search(1, 1'b0);
        tgt = -1;
        track(4, SC, "R8 continuous spacing");
        check(cur == 0, "R13 floor", cur, 0);
        quiet(30, "R12 pending step dropped");

        // R13 saturation at the top
        mode = 2'd2;
        search(30, 1'b0);
        tgt = 50;
        track(4, SC, "R13 ceiling spacing");
        check(int'(drv_bin) == TOP, "R13 ceiling", int'(drv_bin), TOP);
        quiet(30, "R12 stop at top");

        // R10 forced code
        @(negedge clk);
        force_en = 1'b1;
        force_code = CW'(21);
        @(negedge clk);
        check(int'(drv_bin) == 21, "R10 forced driver", int'(drv_bin), 21);
        check(int'(rep_code) == 21, "R10 forced replica", int'(rep_code), 21);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        check(int'(drv_bin) == 21, "R10 start ignored", int'(drv_bin), 21);
        force_en = 1'b0;
        tgt = 3;
        cur = 21;
        quiet(30, "R10 code kept after release");
        check(sb.size() == 0, "R6 all updates seen", sb.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule